// File: doc/BRIEF.md
# Clocked Dual-Read Single-Write Register File

This block is a small register file for a simple datapath. It holds 32 words of 32 bits each. Two read ports and one write port all act on the rising edge of a single clock. On a qualifying edge, each read port loads the word at its address into an output register. On that same edge, the write port stores its input word at the write address. The read outputs then stay put until the next qualifying edge. Because of this, downstream logic such as an ALU sees stable operands for a whole cycle.

A single enable input gates the block. While enable is low, the block ignores every input: no entry changes and neither read output moves. A read and a write to the same address on one edge return the old contents, so reads happen before writes. An active-high synchronous reset clears every entry and both read outputs to zero, whatever the enable is doing.

Top module: `rf3p_top`

## Requirements
- R1: On a rising edge with enable high and reset low, read output A is loaded with the entry selected by read address A. The value is visible after that edge.
- R2: On a rising edge with enable high and reset low, read output B is loaded with the entry selected by read address B. The value is visible after that edge.
- R3: On a rising edge with enable high and reset low, the write data word is stored in the entry selected by the write address.
- R4: Between rising edges, both read outputs hold the values captured on the last qualifying edge.
- R5: On an edge with enable low and reset low, no entry is written and neither read output changes.
- R6: When the write address equals a read address on one enabled edge, that read output returns the entry's contents from before the write. The new word becomes readable from the following enabled edge on.
- R7: With reset high on a rising edge, every entry and both read outputs become zero, whether enable is high or low.
- R8: Addresses are 5 bits wide and select 32 independent entries. Address 0 and address 31 are ordinary storage locations.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high clear of storage and outputs |
| en | input | 1 | Enable; low freezes storage and read outputs |
| rd_addr_a | input | 5 | Read port A address |
| rd_addr_b | input | 5 | Read port B address |
| wr_addr | input | 5 | Write port address |
| wr_data | input | 32 | Word to store |
| rd_data_a | output | 32 | Registered read data, port A |
| rd_data_b | output | 32 | Registered read data, port B |

## Verification
Assertions check four behaviours on every cycle. First, each read output matches the addressed entry from the previous edge. Second, a written entry holds the word presented with it. Third, storage stays frozen while enable is low. Fourth, both outputs stay frozen while enable is low. Some behaviours only the bench's scenarios can show: the read-before-write result on port A and port B, reset clearing contents while enable is low, and use of the extreme addresses 0 and 31. For these, the bench reads back words written in earlier cycles and compares them with values worked out by hand.

// File: rtl/rf3p_pkg.sv
package rf3p_pkg;

    typedef enum logic [1:0] {
        RF_IDLE  = 2'd0,
        RF_LOAD  = 2'd1,
        RF_CLEAR = 2'd2
    } rf_op_e;

    // Reset dominates enable; enable low means nothing moves.
    function automatic rf_op_e rf_op(input logic rst, input logic en);
        if (rst)     return RF_CLEAR;
        else if (en) return RF_LOAD;
        else         return RF_IDLE;
    endfunction

endpackage

// File: rtl/rf_bank.sv
module rf_bank
    import rf3p_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  en,
    input  logic [ADDR_W-1:0]                     wr_addr,
    input  logic [DATA_W-1:0]                     wr_data,
    output logic [(1<<ADDR_W)-1:0][DATA_W-1:0]    entries
);
    localparam int DEPTH = 1 << ADDR_W;

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
    } bank_t;

    bank_t  st_d, st_q;
    rf_op_e op;

    always_comb begin
        st_d = st_q;
        op   = rf_op(rst, en);
        case (op)
            RF_CLEAR: st_d.mem = '0;
            RF_LOAD:  st_d.mem[wr_addr] = wr_data;
            default:  ;
        endcase
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign entries = st_q.mem;

    // R3
    wr_store_chk: assert property (@(posedge clk) disable iff (rst)
        en |=> st_q.mem[$past(wr_addr)] == $past(wr_data));

    // R5
    bank_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(st_q.mem));

endmodule

// File: rtl/rf_rport.sv
module rf_rport
    import rf3p_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  en,
    input  logic [ADDR_W-1:0]                     addr,
    input  logic [(1<<ADDR_W)-1:0][DATA_W-1:0]    entries,
    output logic [DATA_W-1:0]                     dout
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
    } port_t;

    port_t  st_d, st_q;
    rf_op_e op;

    // Samples the bank's current (pre-write) contents: read-before-write.
    always_comb begin
        st_d = st_q;
        op   = rf_op(rst, en);
        case (op)
            RF_CLEAR: st_d.data = '0;
            RF_LOAD:  st_d.data = entries[addr];
            default:  ;
        endcase
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign dout = st_q.data;

    // R1 (port A instance), R2 (port B instance), R6
    rd_capture_chk: assert property (@(posedge clk) disable iff (rst)
        en |=> dout == $past(entries[addr]));

    // R4, R5
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(dout));

endmodule

// File: rtl/rf3p_top.sv
module rf3p_top #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [ADDR_W-1:0] rd_addr_a,
    input  logic [ADDR_W-1:0] rd_addr_b,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data_a,
    output logic [DATA_W-1:0] rd_data_b
);
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int NPORTS = 2;

    logic [DEPTH-1:0][DATA_W-1:0]   entries;
    logic [NPORTS-1:0][ADDR_W-1:0]  rp_addr;
    logic [NPORTS-1:0][DATA_W-1:0]  rp_data;

    assign rp_addr[0] = rd_addr_a;
    assign rp_addr[1] = rd_addr_b;
    assign rd_data_a  = rp_data[0];
    assign rd_data_b  = rp_data[1];

    rf_bank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_bank (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .entries (entries)
    );

    for (genvar p = 0; p < NPORTS; p++) begin : g_rport
        rf_rport #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_rport (
            .clk     (clk),
            .rst     (rst),
            .en      (en),
            .addr    (rp_addr[p]),
            .entries (entries),
            .dout    (rp_data[p])
        );
    end

endmodule

// File: tb/test_rf3p_top.sv
module test_rf3p_top;

    logic        clk = 1'b0;
    logic        rst, en;
    logic [4:0]  rd_addr_a, rd_addr_b, wr_addr;
    logic [31:0] wr_data, rd_data_a, rd_data_b;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;  // 125 MHz

    rf3p_top i_rf3p_top (
        .clk(clk), .rst(rst), .en(en),
        .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b),
        .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_data_a(rd_data_a), .rd_data_b(rd_data_b)
    );

    // {en, ra, rb, wa, wd, exp_a, exp_b}; outputs sampled after the edge
    localparam int NV = 7;
    localparam logic [111:0] VECS [NV] = '{
        {1'b1, 5'd0,  5'd1,  5'd1,  32'd11,         32'd0,          32'd0},          // R6 on B
        {1'b1, 5'd1,  5'd2,  5'd2,  32'd22,         32'd11,         32'd0},          // R1 R6
        {1'b1, 5'd2,  5'd1,  5'd3,  32'd33,         32'd22,         32'd11},         // R1 R2
        {1'b0, 5'd3,  5'd3,  5'd1,  32'd99,         32'd22,         32'd11},         // R5 hold
        {1'b1, 5'd1,  5'd3,  5'd31, 32'hFFFF_FFFF,  32'd11,         32'd33},         // R5 no write, R8
        {1'b1, 5'd31, 5'd31, 5'd31, 32'd5,          32'hFFFF_FFFF,  32'hFFFF_FFFF},  // R6 both, R8
        {1'b1, 5'd31, 5'd2,  5'd0,  32'd7,          32'd5,          32'd22}          // R3 R8
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic e, input logic [4:0] ra, input logic [4:0] rb,
                         input logic [4:0] wa, input logic [31:0] wd);
        @(negedge clk);
        en = e; rd_addr_a = ra; rd_addr_b = rb; wr_addr = wa; wr_data = wd;
        @(posedge clk);
        #2;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; en = 1'b0; rd_addr_a = '0; rd_addr_b = '0; wr_addr = '0; wr_data = '0;
        repeat (3) @(posedge clk);
        #2;
        check("R7 reset A", rd_data_a, 32'd0);
        check("R7 reset B", rd_data_b, 32'd0);
        @(negedge clk); rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            logic [111:0] v;
            v = VECS[i];
            drive(v[111], v[110:106], v[105:101], v[100:96], v[95:64]);
            check($sformatf("R1 vec%0d A", i), rd_data_a, v[63:32]);
            check($sformatf("R2 vec%0d B", i), rd_data_b, v[31:0]);
        end

        // R4: outputs stay put mid-cycle and across disabled edges
        #3;
        check("R4 mid-cycle A", rd_data_a, 32'd5);
        drive(1'b0, 5'd2, 5'd3, 5'd2, 32'hDEAD);
        drive(1'b0, 5'd1, 5'd0, 5'd3, 32'hBEEF);
        check("R4 hold A", rd_data_a, 32'd5);
        check("R4 hold B", rd_data_b, 32'd22);

        // R3 R8: address 0 written with 7, address 31 with 5
        drive(1'b1, 5'd0, 5'd31, 5'd10, 32'hA5A5);
        check("R3 R8 entry0", rd_data_a, 32'd7);
        check("R8 entry31", rd_data_b, 32'd5);
        // R5: disabled writes above left entries 2 and 3 intact
        drive(1'b1, 5'd2, 5'd3, 5'd10, 32'hA5A5);
        check("R5 entry2", rd_data_a, 32'd22);
        check("R5 entry3", rd_data_b, 32'd33);

        // R7: reset with enable low still clears contents and outputs
        @(negedge clk); rst = 1'b1; en = 1'b0;
        @(posedge clk); #2;
        check("R7 out A", rd_data_a, 32'd0);
        check("R7 out B", rd_data_b, 32'd0);
        @(negedge clk); rst = 1'b0;
        drive(1'b1, 5'd10, 5'd31, 5'd4, 32'd1);
        check("R7 entry10", rd_data_a, 32'd0);
        check("R7 entry31", rd_data_b, 32'd0);
        drive(1'b1, 5'd4, 5'd2, 5'd4, 32'd2);
        check("R3 R6 entry4", rd_data_a, 32'd1);
        check("R7 entry2", rd_data_b, 32'd0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule